// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog counter that runs from the moment reset is released. It counts one of two tick sources, both supplied as clock enables in the block's single clock domain: a slow tick, or a tick derived from the system clock. If software does not restart it before the selected period runs out, the block raises a one-cycle reset request. Software restarts the count by writing a fixed key byte (8'hAC) to the restart register. Writing any other byte, or touching that register with a single-bit access, is treated as a fault and also raises the reset request.

A mode register sets the tick source and the period. The mode register accepts exactly one valid write after reset. If that first valid write selects "stopped", the watchdog shuts down for good and no later access can raise a request. While the low-power input is high, the count is frozen and keeps its value.

The controller has three states. FRESH is entered at reset and allows one mode write. ARMED is entered when a valid mode write picks a tick source. LOCKED_OFF is entered when a valid mode write picks stop. A mode write whose reserved bits are wrong leaves the state at FRESH and raises a fault. ARMED and LOCKED_OFF are never left until reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the mode register reads 8'h67: bits 7..5 = 3'b011, bits 4..3 = 2'b00 (slow tick), bits 2..0 = 3'b111 (longest period). Counting of slow ticks starts at once, and no request is raised.
- R2: Mode bits 4..3 select the counted source. 2'b00 counts slow ticks, 2'b01 counts system ticks, and 2'b1x stops counting. Ticks of the source that is not selected have no effect.
- R3: Period code n in mode bits 2..0 gives a period of 2^(BASE_EXP+n) ticks. The tick that completes the period makes reset_req_o high in the following cycle, and the count starts again from zero.
- R4: Any mode-register write clears the count to zero.
- R5: A restart write of 8'hAC without the single-bit flag clears the count and raises no request.
- R6: A restart write of any other byte raises a request in the following cycle.
- R7: A single-bit access to the restart register raises a request in the following cycle, whatever its data.
- R8: A mode write in state ARMED raises a request in the following cycle and leaves the mode register unchanged.
- R9: A mode write with bits 7..5 not equal to 3'b011 raises a request, leaves the mode register unchanged, and keeps the one allowed mode write available.
- R10: A first valid mode write with bit 4 = 1 enters LOCKED_OFF. The mode register then reads the written value, counting stops, and no access or tick raises a request until reset.
- R11: While lowpower_i is high the count holds its value. After lowpower_i falls, counting resumes from the held value with the same source.
- R12: reset_req_o is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | Slow oscillator tick enable |
| sys_tick_i | input | 1 | System clock tick enable |
| lowpower_i | input | 1 | High during halt or stop; freezes the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the mode register, 1 selects the restart register |
| wr_data_i | input | 8 | Write data |
| bit_acc_i | input | 1 | Marks the access as a single-bit access |
| mode_o | output | 8 | Current mode register value |
| reset_req_o | output | 1 | One-cycle internal reset request |

## Verification
A wrong controller state shows up at the ports in one of two ways. The first is a request that appears, or is missing, exactly one cycle after a mode or restart write. The second is mode_o failing to follow an accepted first write. A count that is not cleared, not held, or compared against the wrong period shows as an overflow pulse on the wrong tick. The bench catches this by counting the exact number of ticks up to the pulse for several period codes, and by counting across restarts, mode writes and a low-power freeze. The locked-off state is checked by driving many ticks and every kind of illegal access while watching that reset_req_o stays low.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_FRESH  = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } wdt_state_e;

    localparam logic [7:0] RESTART_KEY  = 8'hAC;
    localparam logic [7:0] MODE_AT_RST  = 8'h67;
    localparam logic [2:0] RSV_PATTERN  = 3'b011;

endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
    import wdt_pkg::*;
(
    input  logic       wr_en_i,
    input  logic       wr_sel_i,
    input  logic [7:0] wr_data_i,
    input  logic       bit_acc_i,
    output logic       mode_wr_o,
    output logic       rsv_ok_o,
    output logic       key_ok_o,
    output logic       restart_bad_o,
    output logic       cnt_clr_o
);

    logic restart_wr;

    always_comb begin
        mode_wr_o     = wr_en_i && !wr_sel_i;
        restart_wr    = wr_en_i && wr_sel_i;
        rsv_ok_o      = (wr_data_i[7:5] == RSV_PATTERN);
        key_ok_o      = restart_wr && !bit_acc_i && (wr_data_i == RESTART_KEY);
        restart_bad_o = restart_wr && (bit_acc_i || (wr_data_i != RESTART_KEY));
        cnt_clr_o     = mode_wr_o || restart_wr;
    end

endmodule

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr_i,
    input  logic       rsv_ok_i,
    input  logic       restart_bad_i,
    input  logic [7:0] wr_data_i,
    input  logic       ovf_i,
    output wdt_state_e state_o,
    output logic [7:0] mode_o,
    output logic       req_o
);

    wdt_state_e state_q, state_d;
    logic [7:0] mode_q, mode_d;
    logic       req_q, fault, req_d;

    // next-state and register-update decisions
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        fault   = 1'b0;
        unique case (state_q)
            ST_FRESH: begin
                if (mode_wr_i && !rsv_ok_i) begin
                    fault = 1'b1;
                end else if (mode_wr_i) begin
                    mode_d  = wr_data_i;
                    state_d = wr_data_i[4] ? ST_LOCKED : ST_ARMED;
                end
                if (restart_bad_i) fault = 1'b1;
            end
            ST_ARMED: begin
                if (mode_wr_i || restart_bad_i) fault = 1'b1;
            end
            ST_LOCKED: begin
                fault = 1'b0;
            end
            default: begin
                state_d = ST_FRESH;
            end
        endcase
        req_d = (fault || (ovf_i && (state_q != ST_LOCKED))) && !req_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FRESH;
            mode_q  <= MODE_AT_RST;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign state_o = state_q;
    assign mode_o  = mode_q;
    assign req_o   = req_q;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int BASE_EXP = 11,
    localparam int CNT_W   = BASE_EXP + 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick_i,
    input  logic             sys_tick_i,
    input  logic             lowpower_i,
    input  logic [1:0]       src_i,
    input  logic [2:0]       period_i,
    input  logic             run_en_i,
    input  logic             clr_i,
    output logic             ovf_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q, limit;
    logic             tick, step;

    always_comb begin
        unique case (src_i)
            2'b00:   tick = slow_tick_i;
            2'b01:   tick = sys_tick_i;
            default: tick = 1'b0;
        endcase
        step  = tick && !lowpower_i && run_en_i;
        limit = {CNT_W{1'b1}} >> (3'd7 - period_i);
        ovf_o = step && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (ovf_o) cnt_q <= '0;
        else if (step)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick_i,
    input  logic       sys_tick_i,
    input  logic       lowpower_i,
    input  logic       wr_en_i,
    input  logic       wr_sel_i,
    input  logic [7:0] wr_data_i,
    input  logic       bit_acc_i,
    output logic [7:0] mode_o,
    output logic       reset_req_o
);

    localparam int CNT_W = BASE_EXP + 7;

    logic             ev_mode_wr, ev_rsv_ok, ev_key_ok, ev_restart_bad, ev_cnt_clr;
    logic             ovf;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       mode_q;
    wdt_state_e       state;

    wdt_bus_decode u_decode (
        .wr_en_i      (wr_en_i),
        .wr_sel_i     (wr_sel_i),
        .wr_data_i    (wr_data_i),
        .bit_acc_i    (bit_acc_i),
        .mode_wr_o    (ev_mode_wr),
        .rsv_ok_o     (ev_rsv_ok),
        .key_ok_o     (ev_key_ok),
        .restart_bad_o(ev_restart_bad),
        .cnt_clr_o    (ev_cnt_clr)
    );

    wdt_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr_i    (ev_mode_wr),
        .rsv_ok_i     (ev_rsv_ok),
        .restart_bad_i(ev_restart_bad),
        .wr_data_i    (wr_data_i),
        .ovf_i        (ovf),
        .state_o      (state),
        .mode_o       (mode_q),
        .req_o        (reset_req_o)
    );

    wdt_counter #(.BASE_EXP(BASE_EXP)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_tick_i(slow_tick_i),
        .sys_tick_i (sys_tick_i),
        .lowpower_i (lowpower_i),
        .src_i      (mode_q[4:3]),
        .period_i   (mode_q[2:0]),
        .run_en_i   (state != ST_LOCKED),
        .clr_i      (ev_cnt_clr),
        .ovf_o      (ovf),
        .cnt_o      (cnt_q)
    );

    assign mode_o = mode_q;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lowpower_i,
    input logic             reset_req_o,
    input wdt_state_e       state,
    input logic [7:0]       mode_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ev_mode_wr,
    input logic             ev_key_ok,
    input logic             ev_cnt_clr,
    input logic             ovf
);

    p_fresh_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRESH) |-> (mode_q == MODE_AT_RST));

    p_mode_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mode_wr |=> (cnt_q == '0));

    p_key_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_key_ok && !ovf) |=> !reset_req_o);

    p_second_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && ev_mode_wr && !reset_req_o) |=> reset_req_o);

    p_locked_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED) |=> (state == ST_LOCKED));

    p_locked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED) |=> !reset_req_o);

    p_freeze_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpower_i && !ev_cnt_clr) |=> $stable(cnt_q));

    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> !reset_req_o);

endmodule

bind keyed_watchdog wdt_checker #(.CNT_W(CNT_W)) u_wdt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lowpower_i (lowpower_i),
    .reset_req_o(reset_req_o),
    .state      (state),
    .mode_q     (mode_q),
    .cnt_q      (cnt_q),
    .ev_mode_wr (ev_mode_wr),
    .ev_key_ok  (ev_key_ok),
    .ev_cnt_clr (ev_cnt_clr),
    .ovf        (ovf)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick_i = 1'b0;
    logic       sys_tick_i = 1'b0;
    logic       lowpower_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_sel_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       bit_acc_i = 1'b0;
    logic [7:0] mode_o;
    logic       reset_req_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    keyed_watchdog #(.BASE_EXP(2)) i_keyed_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_tick_i(slow_tick_i),
        .sys_tick_i (sys_tick_i),
        .lowpower_i (lowpower_i),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .bit_acc_i  (bit_acc_i),
        .mode_o     (mode_o),
        .reset_req_o(reset_req_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one write; then req after the write edge, mode, and req one cycle later
    task automatic do_write(input string tag, input logic sel, input logic ba,
                            input logic [7:0] data, input logic exp_req,
                            input logic [7:0] exp_mode);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; bit_acc_i = ba; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0; bit_acc_i = 1'b0;
        chk({tag, " req"}, 32'(reset_req_o), 32'(exp_req));
        chk({tag, " mode"}, 32'(mode_o), 32'(exp_mode));
        @(negedge clk);
        chk("R12 pulse ends", 32'(reset_req_o), 32'd0);
    endtask

    // which: 0 slow, 1 system, 2 both
    task automatic tick_n(input int n, input int which, output int seen, output logic last);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (reset_req_o) seen++;
            slow_tick_i = (which != 1);
            sys_tick_i  = (which != 0);
        end
        @(negedge clk);
        slow_tick_i = 1'b0;
        sys_tick_i  = 1'b0;
        last = reset_req_o;
    endtask

    // {sel, bit_acc, data, exp_req, exp_mode}
    localparam logic [18:0] VECS [0:7] = '{
        {1'b1, 1'b0, 8'hAC, 1'b0, 8'h67},   // R5 key accepted
        {1'b1, 1'b0, 8'h55, 1'b1, 8'h67},   // R6 wrong key
        {1'b1, 1'b1, 8'hAC, 1'b1, 8'h67},   // R7 single-bit access
        {1'b0, 1'b0, 8'hE1, 1'b1, 8'h67},   // R9 reserved bits wrong
        {1'b0, 1'b0, 8'h6A, 1'b0, 8'h6A},   // R9 first write still allowed
        {1'b1, 1'b0, 8'hAC, 1'b0, 8'h6A},   // R5 key in armed state
        {1'b0, 1'b0, 8'h60, 1'b1, 8'h6A},   // R8 second mode write
        {1'b1, 1'b0, 8'h00, 1'b1, 8'h6A}    // R6 wrong key in armed state
    };

    initial begin
        int   seen;
        logic last;

        // R1 reset state
        do_reset();
        chk("R1 reset mode", 32'(mode_o), 32'h67);
        chk("R1 reset req", 32'(reset_req_o), 32'd0);

        // R2 system ticks ignored by default; R3 longest period = 512 ticks
        tick_n(600, 1, seen, last);
        chk("R2 sys ticks ignored", 32'(seen) + 32'(last), 32'd0);
        tick_n(511, 0, seen, last);
        chk("R3 code7 early", 32'(seen) + 32'(last), 32'd0);
        tick_n(1, 0, seen, last);
        chk("R3 code7 overflow", 32'(last), 32'd1);
        @(negedge clk);
        chk("R12 overflow pulse", 32'(reset_req_o), 32'd0);

        // R4 mode write clears count; code 2 = 16 ticks
        do_reset();
        tick_n(10, 0, seen, last);
        do_write("R4 mode write", 1'b0, 1'b0, 8'h62, 1'b0, 8'h62);
        tick_n(15, 0, seen, last);
        chk("R4 count cleared", 32'(seen) + 32'(last), 32'd0);
        tick_n(1, 0, seen, last);
        chk("R3 code2 overflow", 32'(last), 32'd1);

        // R5 key clears count
        tick_n(10, 0, seen, last);
        do_write("R5 key", 1'b1, 1'b0, 8'hAC, 1'b0, 8'h62);
        tick_n(15, 0, seen, last);
        chk("R5 count cleared", 32'(seen) + 32'(last), 32'd0);
        tick_n(1, 0, seen, last);
        chk("R5 overflow after key", 32'(last), 32'd1);

        // R3 code 0 = 4 ticks
        do_reset();
        do_write("R3 code0 write", 1'b0, 1'b0, 8'h60, 1'b0, 8'h60);
        tick_n(3, 0, seen, last);
        chk("R3 code0 early", 32'(seen) + 32'(last), 32'd0);
        tick_n(1, 0, seen, last);
        chk("R3 code0 overflow", 32'(last), 32'd1);

        // R2 system source, code 1 = 8 ticks
        do_reset();
        do_write("R2 sys select", 1'b0, 1'b0, 8'h69, 1'b0, 8'h69);
        tick_n(20, 0, seen, last);
        chk("R2 slow ticks ignored", 32'(seen) + 32'(last), 32'd0);
        tick_n(7, 1, seen, last);
        chk("R2 sys early", 32'(seen) + 32'(last), 32'd0);
        tick_n(1, 1, seen, last);
        chk("R2 sys overflow", 32'(last), 32'd1);

        // R11 freeze and hold
        do_reset();
        do_write("R11 mode", 1'b0, 1'b0, 8'h61, 1'b0, 8'h61);
        tick_n(5, 0, seen, last);
        lowpower_i = 1'b1;
        tick_n(20, 0, seen, last);
        chk("R11 frozen", 32'(seen) + 32'(last), 32'd0);
        lowpower_i = 1'b0;
        tick_n(2, 0, seen, last);
        chk("R11 resume early", 32'(seen) + 32'(last), 32'd0);
        tick_n(1, 0, seen, last);
        chk("R11 resumed from held value", 32'(last), 32'd1);

        // R10 locked off
        do_reset();
        do_write("R10 stop", 1'b0, 1'b0, 8'h71, 1'b0, 8'h71);
        tick_n(1000, 2, seen, last);
        chk("R10 no overflow", 32'(seen) + 32'(last), 32'd0);
        do_write("R10 bad key", 1'b1, 1'b0, 8'h55, 1'b0, 8'h71);
        do_write("R10 bit access", 1'b1, 1'b1, 8'hAC, 1'b0, 8'h71);
        do_write("R10 second mode", 1'b0, 1'b0, 8'h60, 1'b0, 8'h71);
        do_write("R10 bad reserved", 1'b0, 1'b0, 8'hFF, 1'b0, 8'h71);

        // vector table from a fresh reset: R5 R6 R7 R8 R9
        do_reset();
        for (int v = 0; v < 8; v++) begin
            do_write($sformatf("vec%0d R5-9 table", v), VECS[v][18], VECS[v][17],
                     VECS[v][16:9], VECS[v][8], VECS[v][7:0]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule